// File: doc/BRIEF.md
# Branch Condition Evaluator

This unit sits in the branch path of a small 16-bit microcode sequencer. Each cycle it receives the operation code of the current instruction and its operands. From these it decides whether control flow leaves the sequential path, and it forms the address of the next instruction.

It can test bit masks, and it compares operands as signed or as unsigned numbers. It can also test the sign of the wrapped difference of the two operands. A field test shifts a two-register concatenation right and masks the result. A further condition picks one line of a wide vector of external conditions and applies a polarity.

The unit owns the program counter and a small file of link registers. A call saves the return address in one link register. A return saves the return address in one link register and resumes from another. The two may be the same register. Decode and instruction memory sit outside the unit.

Top module: `br_resolver`

## Requirements
- R1: Code 0 (unconditional) is always taken. For every condition code, `next_pc_o` is `target_i` when the condition is taken and `pc_o`+1 otherwise. Codes 24 to 31 are never taken.
- R2: After reset `pc_o` and all link registers are 0. On a rising edge with `step_i` high, `pc_o` takes `next_pc_o`. With `step_i` low, `pc_o` and the link registers keep their values.
- R3: Code 1 is taken when A AND B is nonzero. Code 2 is taken when A AND B is zero.
- R4: Code 3 is taken when every bit set in B is also set in A. Code 4 is taken when at least one bit set in B is clear in A.
- R5: Code 5 is taken when A equals B. Code 6 is taken when A differs from B.
- R6: Codes 7, 8, 9 and 10 compare A against B as two's-complement numbers. They are taken when A is less, greater-or-equal, greater, and less-or-equal, in that order.
- R7: Codes 11, 12, 13 and 14 make the same four comparisons, in the same order, on A and B read as unsigned numbers.
- R8: Codes 15, 16, 17 and 18 test D = (A - B) mod 2^16. They are taken when D is negative (bit 15 set), non-negative, positive (bit 15 clear and D nonzero), and non-positive, in that order.
- R9: Code 19 forms the 32-bit value {A, B}, with A in the upper half. It shifts that value right by `shamt_i` and keeps the low `msel_i`+1 bits. It is taken when the kept bits are zero. Code 20 is taken when they are nonzero.
- R10: Code 21 is taken when bit `ext_sel_i` of `ext_i` differs from `ext_pol_i`. Polarity 0 therefore jumps on a set line, and polarity 1 jumps on a clear line.
- R11: Code 22 (call) is taken. With `step_i` high, it writes `pc_o`+1 into link register `lnk_wr_i` and loads `target_i` into the program counter.
- R12: Code 23 (return) is taken. `next_pc_o` is the current content of link register `lnk_rd_i`. With `step_i` high, `pc_o`+1 is written into link register `lnk_wr_i`. When both selectors name the same register, the jump uses the value that register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Current instruction retires this cycle |
| op_i | input | 5 | Branch operation code |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B (mask for the bit tests) |
| shamt_i | input | 4 | Right shift for the field test |
| msel_i | input | 4 | Field width minus one for the field test |
| ext_i | input | 64 | External condition lines |
| ext_sel_i | input | 6 | Selected external line |
| ext_pol_i | input | 1 | External polarity: 1 jumps on a clear line |
| target_i | input | 16 | Branch target address |
| lnk_wr_i | input | 2 | Link register written by call or return |
| lnk_rd_i | input | 2 | Link register read by return |
| taken_o | output | 1 | Control flow leaves the sequential path |
| next_pc_o | output | 16 | Address of the next instruction |
| pc_o | output | 16 | Current program counter |

## Verification
The bench builds the unit with its defaults: 16-bit data and program counter, four link registers and 64 external lines. With these defaults, every shift and mask pair fits in a 4-bit field. The top external line, 63, and the widest 32-bit field at shift 15 are also reachable. The default widths bring within reach the overflow corner 0x8000 against 0x0001, where the signed compare and the difference sign disagree. They also allow a return that reads and writes the same link register. Random operands are biased toward equal values and toward the most negative value, so equality and sign boundaries come up often.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [4:0] {
        OP_JMP    = 5'd0,
        OP_JAND   = 5'd1,
        OP_JNAND  = 5'd2,
        OP_JALL   = 5'd3,
        OP_JNALL  = 5'd4,
        OP_JEQ    = 5'd5,
        OP_JNE    = 5'd6,
        OP_JLTS   = 5'd7,
        OP_JGES   = 5'd8,
        OP_JGTS   = 5'd9,
        OP_JLES   = 5'd10,
        OP_JLTU   = 5'd11,
        OP_JGEU   = 5'd12,
        OP_JGTU   = 5'd13,
        OP_JLEU   = 5'd14,
        OP_JDNEG  = 5'd15,
        OP_JDNNEG = 5'd16,
        OP_JDPOS  = 5'd17,
        OP_JDNPOS = 5'd18,
        OP_JFZ    = 5'd19,
        OP_JFNZ   = 5'd20,
        OP_JEXT   = 5'd21,
        OP_CALL   = 5'd22,
        OP_RET    = 5'd23
    } br_op_e;

endpackage

// File: rtl/br_field.sv
module br_field #(
    parameter int DW  = 16,
    parameter int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic [SHW-1:0] msel_i,
    output logic           zero_o
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] pair_d;
    logic [PW-1:0] mask_d;

    always_comb begin
        pair_d = {a_i, b_i} >> shamt_i;
        for (int i = 0; i < PW; i++) begin
            mask_d[i] = (i <= int'(msel_i));
        end
        zero_o = ((pair_d & mask_d) == '0);
    end

endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int DW   = 16,
    parameter int EXTW = 64,
    parameter int SHW  = $clog2(DW),
    parameter int SELW = $clog2(EXTW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  br_op_e          op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic [SHW-1:0]  msel_i,
    input  logic [EXTW-1:0] ext_i,
    input  logic [SELW-1:0] ext_sel_i,
    input  logic            ext_pol_i,
    output logic            taken_o
);
    logic [DW-1:0] diff_d;
    logic          and_nz_d;
    logic          all_d;
    logic          eq_d;
    logic          lts_d;
    logic          ltu_d;
    logic          dneg_d;
    logic          dzero_d;
    logic          fzero_d;

    br_field #(.DW(DW), .SHW(SHW)) u_field (
        .a_i     (a_i),
        .b_i     (b_i),
        .shamt_i (shamt_i),
        .msel_i  (msel_i),
        .zero_o  (fzero_d)
    );

    always_comb begin
        diff_d   = a_i - b_i;
        and_nz_d = ((a_i & b_i) != '0);
        all_d    = ((a_i & b_i) == b_i);
        eq_d     = (a_i == b_i);
        lts_d    = ($signed(a_i) < $signed(b_i));
        ltu_d    = (a_i < b_i);
        dneg_d   = diff_d[DW-1];
        dzero_d  = (diff_d == '0);

        unique case (op_i)
            OP_JMP:    taken_o = 1'b1;
            OP_JAND:   taken_o = and_nz_d;
            OP_JNAND:  taken_o = !and_nz_d;
            OP_JALL:   taken_o = all_d;
            OP_JNALL:  taken_o = !all_d;
            OP_JEQ:    taken_o = eq_d;
            OP_JNE:    taken_o = !eq_d;
            OP_JLTS:   taken_o = lts_d;
            OP_JGES:   taken_o = !lts_d;
            OP_JGTS:   taken_o = !lts_d && !eq_d;
            OP_JLES:   taken_o = lts_d || eq_d;
            OP_JLTU:   taken_o = ltu_d;
            OP_JGEU:   taken_o = !ltu_d;
            OP_JGTU:   taken_o = !ltu_d && !eq_d;
            OP_JLEU:   taken_o = ltu_d || eq_d;
            OP_JDNEG:  taken_o = dneg_d;
            OP_JDNNEG: taken_o = !dneg_d;
            OP_JDPOS:  taken_o = !dneg_d && !dzero_d;
            OP_JDNPOS: taken_o = dneg_d || dzero_d;
            OP_JFZ:    taken_o = fzero_d;
            OP_JFNZ:   taken_o = !fzero_d;
            OP_JEXT:   taken_o = ext_i[ext_sel_i] ^ ext_pol_i;
            OP_CALL:   taken_o = 1'b1;
            OP_RET:    taken_o = 1'b1;
            default:   taken_o = 1'b0;
        endcase
    end

    // R1
    jmp_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JMP) |-> taken_o);

    // R5
    eq_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JEQ && taken_o) |-> (a_i == b_i));

    // R10
    ext_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JEXT && taken_o) |-> (ext_i[ext_sel_i] != ext_pol_i));

    // R6
    signed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JGTS && taken_o) |-> !(op_i == OP_JLES) && (a_i != b_i));

endmodule

// File: rtl/br_resolver.sv
module br_resolver
    import br_pkg::*;
#(
    parameter int DW    = 16,
    parameter int PCW   = 16,
    parameter int NLINK = 4,
    parameter int EXTW  = 64,
    localparam int LW   = $clog2(NLINK),
    localparam int SHW  = $clog2(DW),
    localparam int SELW = $clog2(EXTW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [4:0]      op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic [SHW-1:0]  msel_i,
    input  logic [EXTW-1:0] ext_i,
    input  logic [SELW-1:0] ext_sel_i,
    input  logic            ext_pol_i,
    input  logic [PCW-1:0]  target_i,
    input  logic [LW-1:0]   lnk_wr_i,
    input  logic [LW-1:0]   lnk_rd_i,
    output logic            taken_o,
    output logic [PCW-1:0]  next_pc_o,
    output logic [PCW-1:0]  pc_o
);
    typedef struct packed {
        logic [PCW-1:0]              pc;
        logic [NLINK-1:0][PCW-1:0]   lnk;
    } seq_state_t;

    br_op_e     op_d;
    seq_state_t st_d;
    seq_state_t st_q;
    logic [PCW-1:0] seq_pc_d;
    logic           cond_taken_d;

    assign op_d = br_op_e'(op_i);

    br_cond #(.DW(DW), .EXTW(EXTW), .SHW(SHW), .SELW(SELW)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_d),
        .a_i       (a_i),
        .b_i       (b_i),
        .shamt_i   (shamt_i),
        .msel_i    (msel_i),
        .ext_i     (ext_i),
        .ext_sel_i (ext_sel_i),
        .ext_pol_i (ext_pol_i),
        .taken_o   (cond_taken_d)
    );

    always_comb begin
        st_d     = st_q;
        seq_pc_d = st_q.pc + PCW'(1);
        if (op_d == OP_RET) begin
            next_pc_o = st_q.lnk[lnk_rd_i];
        end else if (cond_taken_d) begin
            next_pc_o = target_i;
        end else begin
            next_pc_o = seq_pc_d;
        end
        if (step_i) begin
            st_d.pc = next_pc_o;
            if (op_d == OP_CALL || op_d == OP_RET) begin
                st_d.lnk[lnk_wr_i] = seq_pc_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o = cond_taken_d;
    assign pc_o    = st_q.pc;

    // R11
    call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && op_d == OP_CALL) |=> (pc_o == $past(target_i)));

    // R12
    ret_old_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && op_d == OP_RET) |=> (pc_o == $past(st_q.lnk[lnk_rd_i])));

    // R2
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o));

    // R1
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !taken_o) |=> (pc_o == $past(pc_o) + PCW'(1)));

endmodule

// File: tb/br_resolver_bench.sv
module br_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_i;
    logic [4:0]  op_i;
    logic [15:0] a_i, b_i;
    logic [3:0]  shamt_i, msel_i;
    logic [63:0] ext_i;
    logic [5:0]  ext_sel_i;
    logic        ext_pol_i;
    logic [15:0] target_i;
    logic [1:0]  lnk_wr_i, lnk_rd_i;
    logic        taken_o;
    logic [15:0] next_pc_o, pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_pc;
    logic [15:0] m_lnk [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolver u_br_resolver (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .msel_i(msel_i),
        .ext_i(ext_i), .ext_sel_i(ext_sel_i), .ext_pol_i(ext_pol_i),
        .target_i(target_i), .lnk_wr_i(lnk_wr_i), .lnk_rd_i(lnk_rd_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .pc_o(pc_o)
    );

    function automatic string req_of(input logic [4:0] op);
        if (op == 0 || op >= 24) return "R1";
        if (op <= 2)  return "R3";
        if (op <= 4)  return "R4";
        if (op <= 6)  return "R5";
        if (op <= 10) return "R6";
        if (op <= 14) return "R7";
        if (op <= 18) return "R8";
        if (op <= 20) return "R9";
        if (op == 21) return "R10";
        if (op == 22) return "R11";
        return "R12";
    endfunction

    function automatic bit field_zero(input logic [15:0] a, input logic [15:0] b,
                                      input logic [3:0] sh, input logic [3:0] ms);
        logic [31:0] p;
        logic [31:0] m;
        p = {a, b} >> sh;
        m = (32'h1 << (int'(ms) + 1)) - 32'h1;
        return (p & m) == 32'h0;
    endfunction

    function automatic bit exp_taken(input logic [4:0] op, input logic [15:0] a,
                                     input logic [15:0] b, input logic [3:0] sh,
                                     input logic [3:0] ms, input logic [63:0] ext,
                                     input logic [5:0] sel, input logic pol);
        logic [15:0] d;
        d = a - b;
        case (op)
            5'd0:  return 1'b1;
            5'd1:  return (a & b) != 0;
            5'd2:  return (a & b) == 0;
            5'd3:  return (a & b) == b;
            5'd4:  return (a & b) != b;
            5'd5:  return a == b;
            5'd6:  return a != b;
            5'd7:  return $signed(a) <  $signed(b);
            5'd8:  return $signed(a) >= $signed(b);
            5'd9:  return $signed(a) >  $signed(b);
            5'd10: return $signed(a) <= $signed(b);
            5'd11: return a <  b;
            5'd12: return a >= b;
            5'd13: return a >  b;
            5'd14: return a <= b;
            5'd15: return d[15];
            5'd16: return !d[15];
            5'd17: return !d[15] && d != 0;
            5'd18: return d[15] || d == 0;
            5'd19: return field_zero(a, b, sh, ms);
            5'd20: return !field_zero(a, b, sh, ms);
            5'd21: return ext[sel] != pol;
            5'd22: return 1'b1;
            5'd23: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one instruction at the falling edge, check outputs, then apply the model update.
    task automatic run(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] sh, input logic [3:0] ms, input logic [63:0] ext,
                       input logic [5:0] sel, input logic pol, input logic [15:0] tgt,
                       input logic [1:0] wr, input logic [1:0] rd, input logic stp);
        bit          et;
        logic [15:0] enp;
        @(negedge clk);
        chk(pc_o == m_pc, "R2", "pc_o", {16'h0, pc_o}, {16'h0, m_pc});
        op_i = op; a_i = a; b_i = b; shamt_i = sh; msel_i = ms; ext_i = ext;
        ext_sel_i = sel; ext_pol_i = pol; target_i = tgt; lnk_wr_i = wr;
        lnk_rd_i = rd; step_i = stp;
        #1;
        et  = exp_taken(op, a, b, sh, ms, ext, sel, pol);
        enp = (op == 5'd23) ? m_lnk[rd] : (et ? tgt : m_pc + 16'd1);
        chk(taken_o == et, req_of(op), "taken_o", {31'h0, taken_o}, {31'h0, et});
        chk(next_pc_o == enp, req_of(op), "next_pc_o", {16'h0, next_pc_o}, {16'h0, enp});
        if (stp) begin
            if (op == 5'd22 || op == 5'd23) m_lnk[wr] = m_pc + 16'd1;
            m_pc = enp;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0]  op;
        logic [15:0] a, b;
        void'($urandom(32'd4242));
        rst_n = 1'b0; step_i = 1'b0; op_i = 5'd31; a_i = '0; b_i = '0;
        shamt_i = '0; msel_i = '0; ext_i = '0; ext_sel_i = '0; ext_pol_i = 1'b0;
        target_i = '0; lnk_wr_i = '0; lnk_rd_i = '0;
        m_pc = '0;
        for (int i = 0; i < 4; i++) m_lnk[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state, then unused code 31 falls through (R1)
        run(5'd31, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h1234, 2'd0, 2'd0, 1'b1);
        // R12 link registers cleared by reset: return from link 3 yields 0
        run(5'd23, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0, 2'd1, 2'd3, 1'b0);
        // R6 / R7 / R8 overflow corner 0x8000 vs 0x0001
        run(5'd7,  16'h8000, 16'h0001, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0100, 2'd0, 2'd0, 1'b0);
        run(5'd11, 16'h8000, 16'h0001, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0100, 2'd0, 2'd0, 1'b0);
        run(5'd17, 16'h8000, 16'h0001, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0100, 2'd0, 2'd0, 1'b0);
        run(5'd18, 16'h1234, 16'h1234, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0100, 2'd0, 2'd0, 1'b0);
        // R9 field crossing the register boundary at shift 15
        run(5'd19, 16'h0001, 16'h0000, 4'd15, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0200, 2'd0, 2'd0, 1'b0);
        run(5'd19, 16'h0001, 16'h0000, 4'd15, 4'd1, 64'h0, 6'd0, 1'b0, 16'h0200, 2'd0, 2'd0, 1'b0);
        run(5'd20, 16'h8000, 16'h0000, 4'd15, 4'd15, 64'h0, 6'd0, 1'b0, 16'h0200, 2'd0, 2'd0, 1'b0);
        // R10 top external line, both polarities
        run(5'd21, 16'h0, 16'h0, 4'd0, 4'd0, 64'h8000_0000_0000_0000, 6'd63, 1'b0, 16'h0300, 2'd0, 2'd0, 1'b0);
        run(5'd21, 16'h0, 16'h0, 4'd0, 4'd0, 64'h8000_0000_0000_0000, 6'd63, 1'b1, 16'h0300, 2'd0, 2'd0, 1'b0);
        // R4 all-bits-set with an empty mask
        run(5'd3, 16'h0000, 16'h0000, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0400, 2'd0, 2'd0, 1'b0);
        // R11 call into link 2, R12 return with the same link for read and write
        run(5'd22, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0040, 2'd2, 2'd0, 1'b1);
        run(5'd23, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0000, 2'd2, 2'd2, 1'b1);
        run(5'd23, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0000, 2'd0, 2'd2, 1'b1);
        // R2 hold with step low on a taken jump
        run(5'd0, 16'h0, 16'h0, 4'd0, 4'd0, 64'h0, 6'd0, 1'b0, 16'h0777, 2'd0, 2'd0, 1'b0);
        // Random mix over every code (R1 to R12)
        for (int n = 0; n < 4000; n++) begin
            op = 5'($urandom % 32);
            a  = 16'($urandom);
            case ($urandom % 8)
                0, 1:    b = a;
                2:       begin a = 16'h8000; b = 16'($urandom); end
                3:       b = a & 16'($urandom);
                default: b = 16'($urandom);
            endcase
            run(op, a, b, 4'($urandom), 4'($urandom), {$urandom, $urandom},
                6'($urandom), 1'($urandom), 16'($urandom), 2'($urandom), 2'($urandom),
                ($urandom % 4) != 0);
        end
        @(negedge clk);
        chk(pc_o == m_pc, "R2", "final pc_o", {16'h0, pc_o}, {16'h0, m_pc});
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule